// File: doc/BRIEF.md
# Fetch-Stage Micro-Op Sequencer

The sequencer sits in the fetch stage next to the instruction cache and decides, every cycle, which of the two supplies the instruction handed to decode. Normally the cache word passes straight through. A load, a store or an exception-entry request starts a stored routine instead. The sequencer then drives a series of single-cycle micro-ops from an internal ROM onto the fetch output, and holds the program counter, until it reaches the ROM entry flagged as the last one. After that it returns the output to the cache.

A load expands into an address-forming add followed by a custom load micro-op. A store expands into an address-forming subtract followed by a custom store micro-op. Exception entry is a three-step routine. Each ROM word is an instruction plus a last-entry flag. The ROM pointer advances one entry per cycle unless the pipeline stall input is high.

Top module: `fetch_seq`

## Requirements
- R1: When idle with no trigger, `instr_o` equals `icache_instr_i`, `valid_o` equals `icache_valid_i`, and `pc_hold_o` is 0.
- R2: A valid cache word whose opcode bits [31:28] are 4'hA (load) is replaced in the same cycle by micro-op 32'h1100_0001. The next advancing cycle gives 32'hE100_0001, which is the last entry.
- R3: Only the first entry appears in the trigger cycle. Every later entry of the routine appears one cycle after the previous entry advanced.
- R4: `pc_hold_o` is 1 from the trigger cycle through the cycle of the last injected micro-op, and `valid_o` is 1 whenever `pc_hold_o` is 1.
- R5: In the cycle after the last entry advances, the output returns to the cache word and `pc_hold_o` returns to 0.
- R6: A valid word with opcode 4'hB (store) injects 32'h2100_0002 and then 32'hE200_0002.
- R7: `exc_req_i` injects 32'h3000_0004, 32'h3000_0005 and 32'hE300_0006. It has priority over a load or store on the cache output in the same cycle.
- R8: While `stall_i` is 1, the current micro-op is presented again in the next cycle. This includes the trigger cycle.
- R9: A load, store or exception request arriving while a routine is active is ignored. The running routine continues unchanged.
- R10: A load opcode with `icache_valid_i` low does not trigger. The cache word passes through with `valid_o` 0.
- R11: Asserting `rst_ni` low in the middle of a routine aborts it. The cache word passes through from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Pipeline stall; freezes the ROM pointer |
| exc_req_i | input | 1 | Exception-entry request |
| icache_instr_i | input | 32 | Instruction word from the cache |
| icache_valid_i | input | 1 | Cache word is valid |
| instr_o | output | 32 | Instruction handed to decode |
| valid_o | output | 1 | Output word is valid |
| pc_hold_o | output | 1 | Hold the program counter |

## Verification
A trigger acts in the same cycle, because the first micro-op and the PC hold follow the inputs combinationally. Each later micro-op is due exactly one clock edge after the previous one advanced, and a stalled cycle repeats the previous word. The bench drives inputs just after a falling edge and pushes the values expected for that same cycle into a queue. A monitor pops and compares the queued values one time unit later, before the next rising edge, so every comparison is tied to the cycle it describes.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
  localparam int IW  = 32;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_LOAD  = 4'hA;
  localparam logic [OPW-1:0] OP_STORE = 4'hB;

  localparam int BASE_LOAD  = 0;
  localparam int BASE_STORE = 2;
  localparam int BASE_EXC   = 4;

  typedef struct packed {
    logic          last;
    logic [IW-1:0] op;
  } rom_word_t;

  // micro-op routines, last flag ends a routine
  function automatic rom_word_t rom_entry(input int idx);
    rom_word_t w;
    case (idx)
      0:       w = '{last: 1'b0, op: 32'h1100_0001}; // load: address add
      1:       w = '{last: 1'b1, op: 32'hE100_0001}; // load: custom access
      2:       w = '{last: 1'b0, op: 32'h2100_0002}; // store: address sub
      3:       w = '{last: 1'b1, op: 32'hE200_0002}; // store: custom access
      4:       w = '{last: 1'b0, op: 32'h3000_0004}; // exception entry
      5:       w = '{last: 1'b0, op: 32'h3000_0005};
      6:       w = '{last: 1'b1, op: 32'hE300_0006};
      default: w = '{last: 1'b1, op: '0};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/fs_trig_dec.sv
module fs_trig_dec
  import fetch_seq_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [OPW-1:0] opcode_i,
  input  logic           valid_i,
  input  logic           exc_req_i,
  output logic           hit_o,
  output logic [AW-1:0]  base_o
);
  always_comb begin
    hit_o  = 1'b0;
    base_o = '0;
    if (exc_req_i) begin
      hit_o  = 1'b1;
      base_o = AW'(BASE_EXC);
    end else if (valid_i && opcode_i == OP_LOAD) begin
      hit_o  = 1'b1;
      base_o = AW'(BASE_LOAD);
    end else if (valid_i && opcode_i == OP_STORE) begin
      hit_o  = 1'b1;
      base_o = AW'(BASE_STORE);
    end
  end
endmodule

// File: rtl/fs_rom.sv
module fs_rom
  import fetch_seq_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [AW-1:0] addr_i,
  output logic          last_o,
  output logic [IW-1:0] op_o
);
  localparam int DEPTH = 1 << AW;

  rom_word_t mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = rom_entry(i);
  end

  assign last_o = mem[addr_i].last;
  assign op_o   = mem[addr_i].op;
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stall_i,
  input  logic          hit_i,
  input  logic [AW-1:0] base_i,
  input  logic          last_i,
  output logic          engage_o,
  output logic [AW-1:0] addr_o
);
  logic          busy_q;
  logic [AW-1:0] ptr_q;

  // new triggers are ignored while a routine runs
  assign engage_o = busy_q | hit_i;
  assign addr_o   = busy_q ? ptr_q : base_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else if (engage_o) begin
      if (stall_i) begin
        busy_q <= 1'b1;
        ptr_q  <= addr_o;
      end else if (last_i) begin
        busy_q <= 1'b0;
      end else begin
        busy_q <= 1'b1;
        ptr_q  <= addr_o + 1'b1;
      end
    end
  end

  // R8
  stall_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && stall_i |=> busy_q && $stable(ptr_q));

  // R9
  no_retrigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && hit_i && !stall_i && !last_i |=> busy_q && ptr_q == $past(ptr_q) + 1'b1);

  // R5
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    engage_o && last_i && !stall_i |=> !busy_q);

  // R3
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && hit_i && !stall_i && !last_i |=> busy_q && ptr_q == $past(base_i) + 1'b1);
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_seq_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stall_i,
  input  logic          exc_req_i,
  input  logic [31:0]   icache_instr_i,
  input  logic          icache_valid_i,
  output logic [31:0]   instr_o,
  output logic          valid_o,
  output logic          pc_hold_o
);
  logic          hit;
  logic [AW-1:0] base;
  logic [AW-1:0] addr;
  logic          last;
  logic          engage;
  logic [IW-1:0] rom_op;

  fs_trig_dec #(.AW(AW)) u_dec (
    .opcode_i  (icache_instr_i[IW-1 -: OPW]),
    .valid_i   (icache_valid_i),
    .exc_req_i (exc_req_i),
    .hit_o     (hit),
    .base_o    (base)
  );

  fs_ctrl #(.AW(AW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stall_i  (stall_i),
    .hit_i    (hit),
    .base_i   (base),
    .last_i   (last),
    .engage_o (engage),
    .addr_o   (addr)
  );

  fs_rom #(.AW(AW)) u_rom (
    .addr_i (addr),
    .last_o (last),
    .op_o   (rom_op)
  );

  assign instr_o   = engage ? rom_op : icache_instr_i;
  assign valid_o   = engage | icache_valid_i;
  assign pc_hold_o = engage;

  // R4
  hold_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_hold_o |-> valid_o);
endmodule

// File: tb/fetch_seq_bench.sv
`timescale 1ns/1ps
module fetch_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stall_i = 1'b0;
  logic        exc_req_i = 1'b0;
  logic [31:0] icache_instr_i = '0;
  logic        icache_valid_i = 1'b0;
  logic [31:0] instr_o;
  logic        valid_o;
  logic        pc_hold_o;

  always #2.5 clk_i = ~clk_i;

  fetch_seq u_fetch_seq (
    .clk_i, .rst_ni, .stall_i, .exc_req_i, .icache_instr_i, .icache_valid_i,
    .instr_o, .valid_o, .pc_hold_o
  );

  typedef struct {
    logic [31:0] instr;
    logic        valid;
    logic        hold;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  localparam logic [31:0] PLAIN = 32'h0000_1234;
  localparam logic [31:0] LDW   = 32'hA000_0010;
  localparam logic [31:0] STW   = 32'hB000_0020;

  task automatic step(input logic r, input logic [31:0] ins, input logic v,
                      input logic e, input logic s,
                      input logic [31:0] ei, input logic ev, input logic eh,
                      input string req);
    exp_t x;
    @(negedge clk_i);
    rst_ni = r; icache_instr_i = ins; icache_valid_i = v;
    exc_req_i = e; stall_i = s;
    x.instr = ei; x.valid = ev; x.hold = eh; x.req = req;
    exp_q.push_back(x);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        exp_t x;
        x = exp_q.pop_front();
        total++;
        if (instr_o !== x.instr || valid_o !== x.valid || pc_hold_o !== x.hold) begin
          bad++;
          $display("FAIL %s: got instr=%h valid=%b hold=%b exp instr=%h valid=%b hold=%b",
                   x.req, instr_o, valid_o, pc_hold_o, x.instr, x.valid, x.hold);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state and pass-through
    step(1, PLAIN, 1, 0, 0, PLAIN, 1, 0, "R1");
    step(1, 32'h1234_5678, 0, 0, 0, 32'h1234_5678, 0, 0, "R1");
    // R2 R3 R4 R5 load
    step(1, LDW,   1, 0, 0, 32'h1100_0001, 1, 1, "R2");
    step(1, PLAIN, 1, 0, 0, 32'hE100_0001, 1, 1, "R3");
    step(1, PLAIN, 1, 0, 0, PLAIN, 1, 0, "R5");
    // R6 store
    step(1, STW,   1, 0, 0, 32'h2100_0002, 1, 1, "R6");
    step(1, PLAIN, 0, 0, 0, 32'hE200_0002, 1, 1, "R6");
    step(1, PLAIN, 0, 0, 0, PLAIN, 0, 0, "R5");
    // R7 exception wins over load
    step(1, LDW,   1, 1, 0, 32'h3000_0004, 1, 1, "R7");
    step(1, PLAIN, 1, 0, 0, 32'h3000_0005, 1, 1, "R7");
    step(1, PLAIN, 1, 0, 0, 32'hE300_0006, 1, 1, "R7");
    step(1, PLAIN, 1, 0, 0, PLAIN, 1, 0, "R4");
    // R8 stall in trigger cycle and mid-routine
    step(1, LDW,   1, 0, 1, 32'h1100_0001, 1, 1, "R8");
    step(1, LDW,   1, 0, 0, 32'h1100_0001, 1, 1, "R8");
    step(1, PLAIN, 1, 0, 1, 32'hE100_0001, 1, 1, "R8");
    step(1, PLAIN, 1, 0, 0, 32'hE100_0001, 1, 1, "R8");
    step(1, PLAIN, 1, 0, 0, PLAIN, 1, 0, "R8");
    // R9 triggers ignored while busy
    step(1, PLAIN, 1, 1, 0, 32'h3000_0004, 1, 1, "R9");
    step(1, STW,   1, 1, 0, 32'h3000_0005, 1, 1, "R9");
    step(1, STW,   1, 0, 0, 32'hE300_0006, 1, 1, "R9");
    step(1, STW,   1, 0, 0, 32'h2100_0002, 1, 1, "R9");
    step(1, PLAIN, 1, 0, 0, 32'hE200_0002, 1, 1, "R9");
    // R10 invalid load does not trigger
    step(1, LDW,   0, 0, 0, LDW, 0, 0, "R10");
    step(1, PLAIN, 1, 0, 0, PLAIN, 1, 0, "R10");
    // R11 reset mid-routine
    step(1, LDW,   1, 0, 0, 32'h1100_0001, 1, 1, "R11");
    step(0, PLAIN, 1, 0, 0, PLAIN, 1, 0, "R11");
    step(1, PLAIN, 1, 0, 0, PLAIN, 1, 0, "R11");
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule